// File: doc/BRIEF.md
# Frame-Synchronous Exposure Shadow Registers

This block sits between a host register bus and a pixel array. The host writes coarse exposure, fine exposure, analogue gain and a clock-division code into a small page of shadow registers. The array never sees those writes directly. The values move into the active registers only on a frame-start pulse, so a frame is never exposed with a mix of old and new settings.

Gain reaches the array one frame after the exposure values that were written with it. Exposure affects the frame read out one frame later, while gain affects the current readout, so the extra frame makes the two line up in the output.

While the host is in the middle of a burst of writes to the page, all transfers are held off. A half-written set of values can therefore never be applied. Values that lie outside the legal range are clipped as they are applied. A status byte shows, for each field, whether a written value is still waiting, and carries a bit that flips on every frame.

Top module: `exp_shadow_top`

## Requirements
- R1: The active coarse exposure, fine exposure and division code change only at the clock edge where `frame_start` is sampled high and no transfer freeze is in force. At that edge each field that has a pending write takes its shadow value after clipping.
- R2: `status[0]` flags pending fine exposure, `status[1]` pending coarse exposure, `status[2]` pending gain and `status[3]` a pending division code. Each bit is set by a write to its field and cleared once that value has been applied.
- R3: A pending gain is captured into a one-frame stage at the first unfrozen frame start and driven onto `act_gain` at the next unfrozen frame start. `status[2]` stays high until the gain reaches `act_gain`.
- R4: Coarse exposure is applied as min(value, `frame_len` − 2), or as 0 when `frame_len` < 2.
- R5: Fine exposure is applied as min(value, `line_len`) and raised to 11 if the result is below 11.
- R6: A division code above 4 is applied as 4.
- R7: A write to the page starts a burst, which freezes transfers. The burst ends on `bus_stop` or on a write outside the page. A frame start seen during a burst transfers nothing, and the values move at the next unfrozen frame start.
- R8: The page is the set of indices whose bits [6:3] equal those of `PAGE_BASE` (default 0x30). The field offsets within the page are:
  - +0 coarse high, bits [1:0]
  - +1 coarse low, 8 bits
  - +2 fine high, bits [1:0]
  - +3 fine low, 8 bits
  - +4 gain, bits [3:0]
  - +5 division code, bits [2:0]
- R9: `rd_data` returns the stored written value of the field at `rd_idx`, zero-extended, even when that value has not yet been applied. Offsets +6 and +7, and any index outside the page, read 0.
- R10: `status[4]` toggles at every `frame_start`, frozen or not. `status[7:5]` are always 0.
- R11: After reset, the active and shadow values are coarse 522, fine 762, gain 0 and division code 0, and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 7 | Host write register index |
| wr_data | input | 8 | Host write data |
| bus_stop | input | 1 | Pulse marking the end of a host bus transaction |
| rd_idx | input | 7 | Host read register index |
| rd_data | output | 8 | Written value of the addressed field |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| frame_len | input | 10 | Lines per frame, used for coarse clipping |
| line_len | input | 10 | Pixels per line, used for fine clipping |
| act_coarse | output | 10 | Active coarse exposure |
| act_fine | output | 10 | Active fine exposure |
| act_gain | output | 4 | Active gain code |
| act_div | output | 3 | Active clock-division code |
| status | output | 8 | Pending flags and frame toggle |

## Verification
The assertions check the timing rules on every cycle:
- Active values move only at an unfrozen frame start.
- A frozen frame start leaves every active value unchanged.
- The gain output moves only from a stage that was full the cycle before.
- A gain write raises its pending flag.
- The frame toggle flips exactly on frame starts.
- Applied exposures respect their clip bounds.

Only the bench scenarios can show the following, because they depend on a history of writes and frames:
- The exact clipped numbers.
- The two-frame journey of a gain value.
- The deferral of a transfer until a burst ends.
- That read-back shows the pending value rather than the active one.

// File: rtl/exp_shadow_pkg.sv
package exp_shadow_pkg;

  localparam int EXP_W  = 10;
  localparam int GAIN_W = 4;
  localparam int DIV_W  = 3;
  localparam int IDX_W  = 7;

  localparam logic [2:0] OFS_CO_HI = 3'd0;
  localparam logic [2:0] OFS_CO_LO = 3'd1;
  localparam logic [2:0] OFS_FI_HI = 3'd2;
  localparam logic [2:0] OFS_FI_LO = 3'd3;
  localparam logic [2:0] OFS_GAIN  = 3'd4;
  localparam logic [2:0] OFS_DIV   = 3'd5;

  // pending bit positions in the status byte
  localparam int PB_FINE   = 0;
  localparam int PB_COARSE = 1;
  localparam int PB_GAIN   = 2;
  localparam int PB_DIV    = 3;
  localparam int N_PEND    = 4;

  localparam logic [EXP_W-1:0] FINE_MIN = EXP_W'(11);
  localparam logic [DIV_W-1:0] DIV_MAX  = DIV_W'(4);

  function automatic logic [EXP_W-1:0] clip_coarse(input logic [EXP_W-1:0] v,
                                                   input logic [EXP_W-1:0] flen);
    logic [EXP_W-1:0] lim;
    lim = (flen < EXP_W'(2)) ? '0 : flen - EXP_W'(2);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [EXP_W-1:0] clip_fine(input logic [EXP_W-1:0] v,
                                                 input logic [EXP_W-1:0] llen);
    logic [EXP_W-1:0] t;
    t = (v > llen) ? llen : v;
    return (t < FINE_MIN) ? FINE_MIN : t;
  endfunction

  function automatic logic [DIV_W-1:0] clip_div(input logic [DIV_W-1:0] v);
    return (v > DIV_MAX) ? DIV_MAX : v;
  endfunction

endpackage

// File: rtl/exp_shadow_regs.sv
module exp_shadow_regs
  import exp_shadow_pkg::*;
#(
  parameter logic [IDX_W-1:0]  PAGE_BASE  = 7'h30,
  parameter logic [EXP_W-1:0]  RST_COARSE = 10'd522,
  parameter logic [EXP_W-1:0]  RST_FINE   = 10'd762,
  parameter logic [GAIN_W-1:0] RST_GAIN   = '0,
  parameter logic [DIV_W-1:0]  RST_DIV    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  input  logic [N_PEND-1:0] consume,
  output logic [N_PEND-1:0] pend,
  output logic              page_wr,
  output logic              other_wr,
  output logic [EXP_W-1:0]  sh_coarse,
  output logic [EXP_W-1:0]  sh_fine,
  output logic [GAIN_W-1:0] sh_gain,
  output logic [DIV_W-1:0]  sh_div
);
  localparam int HI_W = EXP_W - 8;

  logic [2:0] wr_ofs, rd_ofs;
  logic rd_in_page;
  logic [N_PEND-1:0] set_v;

  assign page_wr    = wr_en && (wr_idx[IDX_W-1:3] == PAGE_BASE[IDX_W-1:3]);
  assign other_wr   = wr_en && !page_wr;
  assign wr_ofs     = wr_idx[2:0];
  assign rd_ofs     = rd_idx[2:0];
  assign rd_in_page = (rd_idx[IDX_W-1:3] == PAGE_BASE[IDX_W-1:3]);

  always_comb begin
    set_v = '0;
    set_v[PB_COARSE] = page_wr && (wr_ofs == OFS_CO_HI || wr_ofs == OFS_CO_LO);
    set_v[PB_FINE]   = page_wr && (wr_ofs == OFS_FI_HI || wr_ofs == OFS_FI_LO);
    set_v[PB_GAIN]   = page_wr && (wr_ofs == OFS_GAIN);
    set_v[PB_DIV]    = page_wr && (wr_ofs == OFS_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_coarse <= RST_COARSE;
      sh_fine   <= RST_FINE;
      sh_gain   <= RST_GAIN;
      sh_div    <= RST_DIV;
    end else if (page_wr) begin
      case (wr_ofs)
        OFS_CO_HI: sh_coarse[EXP_W-1:8] <= wr_data[HI_W-1:0];
        OFS_CO_LO: sh_coarse[7:0]       <= wr_data;
        OFS_FI_HI: sh_fine[EXP_W-1:8]   <= wr_data[HI_W-1:0];
        OFS_FI_LO: sh_fine[7:0]         <= wr_data;
        OFS_GAIN:  sh_gain              <= wr_data[GAIN_W-1:0];
        OFS_DIV:   sh_div               <= wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // one pending flag per field: a write wins over a same-cycle consume
  for (genvar g = 0; g < N_PEND; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[g] <= 1'b0;
      else if (set_v[g])   pend[g] <= 1'b1;
      else if (consume[g]) pend[g] <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_in_page) begin
      case (rd_ofs)
        OFS_CO_HI: rd_data = 8'(sh_coarse[EXP_W-1:8]);
        OFS_CO_LO: rd_data = sh_coarse[7:0];
        OFS_FI_HI: rd_data = 8'(sh_fine[EXP_W-1:8]);
        OFS_FI_LO: rd_data = sh_fine[7:0];
        OFS_GAIN:  rd_data = 8'(sh_gain);
        OFS_DIV:   rd_data = 8'(sh_div);
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/exp_shadow_burst.sv
module exp_shadow_burst (
  input  logic clk,
  input  logic rst_n,
  input  logic page_wr,
  input  logic other_wr,
  input  logic bus_stop,
  output logic burst_q,
  output logic frozen
);
  // a page write in the current cycle freezes as well as an open burst
  assign frozen = burst_q || page_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)                    burst_q <= 1'b0;
    else if (page_wr)              burst_q <= 1'b1;
    else if (bus_stop || other_wr) burst_q <= 1'b0;
  end
endmodule

// File: rtl/exp_shadow_apply.sv
module exp_shadow_apply
  import exp_shadow_pkg::*;
#(
  parameter logic [EXP_W-1:0]  RST_COARSE = 10'd522,
  parameter logic [EXP_W-1:0]  RST_FINE   = 10'd762,
  parameter logic [GAIN_W-1:0] RST_GAIN   = '0,
  parameter logic [DIV_W-1:0]  RST_DIV    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frozen,
  input  logic [N_PEND-1:0] pend,
  input  logic [EXP_W-1:0]  sh_coarse,
  input  logic [EXP_W-1:0]  sh_fine,
  input  logic [GAIN_W-1:0] sh_gain,
  input  logic [DIV_W-1:0]  sh_div,
  input  logic [EXP_W-1:0]  frame_len,
  input  logic [EXP_W-1:0]  line_len,
  output logic              xfer,
  output logic [N_PEND-1:0] consume,
  output logic              stage_vld,
  output logic              frame_tog,
  output logic [EXP_W-1:0]  act_coarse,
  output logic [EXP_W-1:0]  act_fine,
  output logic [GAIN_W-1:0] act_gain,
  output logic [DIV_W-1:0]  act_div
);
  logic [GAIN_W-1:0] gain_stage;

  assign xfer    = frame_start && !frozen;
  assign consume = xfer ? pend : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_coarse <= RST_COARSE;
      act_fine   <= RST_FINE;
      act_gain   <= RST_GAIN;
      act_div    <= RST_DIV;
      gain_stage <= RST_GAIN;
      stage_vld  <= 1'b0;
      frame_tog  <= 1'b0;
    end else begin
      if (frame_start) frame_tog <= !frame_tog;
      if (xfer) begin
        if (pend[PB_COARSE]) act_coarse <= clip_coarse(sh_coarse, frame_len);
        if (pend[PB_FINE])   act_fine   <= clip_fine(sh_fine, line_len);
        if (pend[PB_DIV])    act_div    <= clip_div(sh_div);
        if (stage_vld) begin
          act_gain  <= gain_stage;
          stage_vld <= 1'b0;
        end
        if (pend[PB_GAIN]) begin
          gain_stage <= sh_gain;
          stage_vld  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/exp_shadow_top.sv
module exp_shadow_top
  import exp_shadow_pkg::*;
#(
  parameter logic [IDX_W-1:0]  PAGE_BASE  = 7'h30,
  parameter logic [EXP_W-1:0]  RST_COARSE = 10'd522,
  parameter logic [EXP_W-1:0]  RST_FINE   = 10'd762,
  parameter logic [GAIN_W-1:0] RST_GAIN   = '0,
  parameter logic [DIV_W-1:0]  RST_DIV    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              bus_stop,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  input  logic              frame_start,
  input  logic [EXP_W-1:0]  frame_len,
  input  logic [EXP_W-1:0]  line_len,
  output logic [EXP_W-1:0]  act_coarse,
  output logic [EXP_W-1:0]  act_fine,
  output logic [GAIN_W-1:0] act_gain,
  output logic [DIV_W-1:0]  act_div,
  output logic [7:0]        status
);
  logic [N_PEND-1:0] pend, consume;
  logic page_wr, other_wr, burst_q, frozen, xfer_evt, stage_vld, frame_tog;
  logic [EXP_W-1:0]  sh_coarse, sh_fine;
  logic [GAIN_W-1:0] sh_gain;
  logic [DIV_W-1:0]  sh_div;

  exp_shadow_regs #(
    .PAGE_BASE(PAGE_BASE), .RST_COARSE(RST_COARSE), .RST_FINE(RST_FINE),
    .RST_GAIN(RST_GAIN), .RST_DIV(RST_DIV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .consume(consume), .pend(pend),
    .page_wr(page_wr), .other_wr(other_wr), .sh_coarse(sh_coarse),
    .sh_fine(sh_fine), .sh_gain(sh_gain), .sh_div(sh_div)
  );

  exp_shadow_burst u_burst (
    .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .other_wr(other_wr),
    .bus_stop(bus_stop), .burst_q(burst_q), .frozen(frozen)
  );

  exp_shadow_apply #(
    .RST_COARSE(RST_COARSE), .RST_FINE(RST_FINE),
    .RST_GAIN(RST_GAIN), .RST_DIV(RST_DIV)
  ) u_apply (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frozen(frozen),
    .pend(pend), .sh_coarse(sh_coarse), .sh_fine(sh_fine), .sh_gain(sh_gain),
    .sh_div(sh_div), .frame_len(frame_len), .line_len(line_len),
    .xfer(xfer_evt), .consume(consume), .stage_vld(stage_vld),
    .frame_tog(frame_tog), .act_coarse(act_coarse), .act_fine(act_fine),
    .act_gain(act_gain), .act_div(act_div)
  );

  assign status = {3'b000, frame_tog, pend[PB_DIV], pend[PB_GAIN] | stage_vld,
                   pend[PB_COARSE], pend[PB_FINE]};
endmodule

// File: rtl/exp_shadow_chk.sv
module exp_shadow_chk
  import exp_shadow_pkg::*;
#(
  parameter logic [IDX_W-1:0] PAGE_BASE = 7'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              frame_start,
  input logic              frozen,
  input logic              xfer_evt,
  input logic              stage_vld,
  input logic [EXP_W-1:0]  frame_len,
  input logic [EXP_W-1:0]  act_coarse,
  input logic [EXP_W-1:0]  act_fine,
  input logic [GAIN_W-1:0] act_gain,
  input logic [DIV_W-1:0]  act_div,
  input logic [7:0]        status
);
  localparam logic [IDX_W-1:0] GAIN_IDX = PAGE_BASE + IDX_W'(OFS_GAIN);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && !frozen) |=> $stable({act_coarse, act_fine, act_div}));

  p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == GAIN_IDX) |=> status[2]);

  p_gain_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_gain) |-> $past(stage_vld));

  p_coarse_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && status[1] && frame_len >= EXP_W'(2))
      |=> act_coarse <= $past(frame_len) - EXP_W'(2));

  p_fine_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && status[0]) |=> act_fine >= EXP_W'(11));

  p_div_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_div <= DIV_W'(4));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frozen) |=> $stable({act_coarse, act_fine, act_gain, act_div}));

  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> status[4] != $past(status[4]));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(status[4]));

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000);
endmodule

bind exp_shadow_top exp_shadow_chk #(.PAGE_BASE(PAGE_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .frame_start(frame_start), .frozen(frozen), .xfer_evt(xfer_evt),
  .stage_vld(stage_vld), .frame_len(frame_len), .act_coarse(act_coarse),
  .act_fine(act_fine), .act_gain(act_gain), .act_div(act_div), .status(status)
);

// File: tb/sim_exp_shadow_top.sv
`timescale 1ns/1ps
module sim_exp_shadow_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, bus_stop = 1'b0, frame_start = 1'b0;
  logic [6:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_data = '0, rd_data, status;
  logic [9:0] frame_len = 10'd524, line_len = 10'd762, act_coarse, act_fine;
  logic [3:0] act_gain;
  logic [2:0] act_div;
  int checks = 0, failures = 0;
  bit tog = 1'b0, done = 1'b0;

  localparam logic [6:0] PB = 7'h30;

  always #10 clk = !clk;

  exp_shadow_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .bus_stop(bus_stop), .rd_idx(rd_idx), .rd_data(rd_data),
    .frame_start(frame_start), .frame_len(frame_len), .line_len(line_len),
    .act_coarse(act_coarse), .act_fine(act_fine), .act_gain(act_gain),
    .act_div(act_div), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    tog = !tog;
  endtask

  task automatic rd(input string req, input logic [6:0] idx, input int exp);
    @(negedge clk); rd_idx = idx; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R11 coarse", act_coarse, 522);
    chk("R11 fine", act_fine, 762);
    chk("R11 gain", act_gain, 0);
    chk("R11 div", act_div, 0);
    chk("R11 status", status, 0);
  endtask

  task automatic t_coarse();
    wr(PB + 7'd0, 8'd0); wr(PB + 7'd1, 8'd100); stop();
    chk("R2 coarse pending", status[1], 1);
    chk("R1 no early apply", act_coarse, 522);
    rd("R9 read pending", PB + 7'd1, 100);
    frame();
    chk("R1 coarse applied", act_coarse, 100);
    chk("R2 coarse cleared", status[1], 0);
    chk("R10 toggle", status[4], int'(tog));
  endtask

  task automatic t_gain();
    wr(PB + 7'd4, 8'd9); stop();
    chk("R2 gain pending", status[2], 1);
    frame();
    chk("R3 gain held one frame", act_gain, 0);
    chk("R3 gain still pending", status[2], 1);
    frame();
    chk("R3 gain applied", act_gain, 9);
    chk("R3 gain pending cleared", status[2], 0);
    chk("R10 toggle", status[4], int'(tog));
  endtask

  task automatic t_clip();
    wr(PB + 7'd0, 8'd3); wr(PB + 7'd1, 8'hE8);
    wr(PB + 7'd2, 8'd0); wr(PB + 7'd3, 8'd5);
    wr(PB + 7'd5, 8'd7); stop();
    frame();
    chk("R4 coarse clip", act_coarse, 522);
    chk("R5 fine floor", act_fine, 11);
    chk("R6 div clip", act_div, 4);
    rd("R9 div read raw", PB + 7'd5, 7);
    rd("R9 coarse hi read", PB + 7'd0, 3);
    wr(PB + 7'd2, 8'd3); wr(PB + 7'd3, 8'h84); stop();
    frame_len = 10'd300;
    wr(PB + 7'd0, 8'd1); wr(PB + 7'd1, 8'h90); stop();
    frame();
    chk("R5 fine ceiling", act_fine, 762);
    chk("R4 coarse clip short frame", act_coarse, 298);
    frame_len = 10'd1;
    wr(PB + 7'd1, 8'd5); stop();
    frame();
    chk("R4 coarse tiny frame", act_coarse, 0);
    frame_len = 10'd524;
  endtask

  task automatic t_freeze();
    wr(PB + 7'd0, 8'd0); wr(PB + 7'd1, 8'd50);
    frame();
    chk("R7 frozen no apply", act_coarse, 0);
    chk("R7 frozen still pending", status[1], 1);
    chk("R10 toggle while frozen", status[4], int'(tog));
    stop();
    frame();
    chk("R7 deferred apply", act_coarse, 50);
    wr(PB + 7'd2, 8'd0); wr(PB + 7'd3, 8'd200); wr(7'h10, 8'd1);
    frame();
    chk("R7 burst ended by other write", act_fine, 200);
  endtask

  task automatic t_read();
    wr(PB + 7'd3, 8'd77); stop();
    rd("R9 read shows pending", PB + 7'd3, 77);
    chk("R9 active untouched", act_fine, 200);
    rd("R9 unused offset", PB + 7'd6, 0);
    rd("R9 outside page", 7'h10, 0);
    rd("R8 gain field", PB + 7'd4, 9);
    frame();
    chk("R10 high bits zero", status[7:5], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_coarse();
    t_gain();
    t_clip();
    t_freeze();
    t_read();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule